// File: doc/BRIEF.md
# Trapping Integer Add/Subtract Unit

This unit is the add/subtract stage of a simple processor datapath. It works on two's-complement words. The first operand always comes from a register. The second operand comes either from a register or from a short immediate, which is sign-extended to the full data width. Subtraction is done by adding the bitwise inverse of the second operand with a carry-in of one.

Every operation has two forms: one that traps and one that does not. Both forms flag signed overflow, which is derived from the signs of the operands and the result. Only the trapping form turns that overflow into an exception request. On an exception request the destination write is withheld, the address of the faulting instruction is captured, and a cause code records which kind of operation overflowed.

All outputs come from a single register stage, so they appear on the clock edge that samples the strobe. Exception vectoring, the register file and instruction decode live outside this unit.

Top module: `trap_addsub`

## Requirements
- R1: While rst_ni is low, every output is zero: result_o, ovf_o, wr_en_o, exc_o, epc_o and cause_o.
- R2: The op_i codes are: 000 add, 001 add without trap, 010 add immediate, 011 add immediate without trap, 100 subtract, 101 subtract without trap. For 000 and 001, result_o equals (opa_i + opb_i) modulo 2^DATA_W. It appears at the first rising edge that samples valid_i high.
- R3: For codes 010 and 011, opb_i is ignored. The second operand is imm_i with bit IMM_W-1 copied into every upper bit.
- R4: For codes 100 and 101, result_o equals opa_i + ~opb_i + 1 modulo 2^DATA_W.
- R5: For the add forms, ovf_o is 1 only when both operands have the same sign and the sign of the result differs from it. Operands of opposite sign never set ovf_o.
- R6: For the subtract forms, ovf_o is 1 only when the operand signs differ and the sign of the result differs from the sign of opa_i. ovf_o is reported for trapping and non-trapping codes alike.
- R7: For a trapping code (op_i bit 0 equal to 0) that overflows, exc_o is 1 and wr_en_o is 0 for the one cycle after the strobe.
- R8: A non-trapping code (op_i bit 0 equal to 1) never raises exc_o. It sets wr_en_o in the cycle after the strobe even when ovf_o is 1.
- R9: When exc_o rises, epc_o holds the pc_i that was sampled with the strobe. cause_o holds 01 for an add or add-immediate overflow and 10 for a subtract overflow. Both outputs keep their values until the next exception.
- R10: Subtracting the most negative value (only the top bit set) from a non-negative opa_i sets ovf_o. For code 100 it also raises exc_o.
- R11: A cycle with valid_i low, or with the reserved codes 110 or 111, drives wr_en_o and exc_o low in the following cycle. result_o and ovf_o keep their earlier values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code |
| opa_i | input | DATA_W | First register operand |
| opb_i | input | DATA_W | Second register operand |
| imm_i | input | IMM_W | Immediate operand |
| pc_i | input | ADDR_W | Address of the current instruction |
| result_o | output | DATA_W | Registered sum or difference |
| ovf_o | output | 1 | Registered raw signed overflow |
| wr_en_o | output | 1 | Destination write enable |
| exc_o | output | 1 | Exception request pulse |
| epc_o | output | ADDR_W | Address captured at the last exception |
| cause_o | output | 2 | Cause of the last exception |

## Verification
Two functions can fall in the same output cycle. The first is the exception request together with its address and cause capture, for one instruction. The second is a fresh result from the next instruction. The sweep issues operations back to back with no gaps, so trapping overflows often follow one another or sit next to non-trapping ones. In those cases epc_o must carry the newest faulting address, and a non-trapping overflow must leave the captured address alone. Idle cycles and reserved codes are placed between runs. The bench then checks that the held result, the held flag and the captured state all survive them unchanged.

// File: rtl/trap_addsub_pkg.sv
package trap_addsub_pkg;
  typedef enum logic [2:0] {
    OP_ADD   = 3'b000,
    OP_ADDU  = 3'b001,
    OP_ADDI  = 3'b010,
    OP_ADDIU = 3'b011,
    OP_SUB   = 3'b100,
    OP_SUBU  = 3'b101
  } op_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_ADD  = 2'b01,
    CAUSE_SUB  = 2'b10
  } cause_e;

  function automatic logic op_legal(input logic [2:0] op);
    return op[2:1] != 2'b11;
  endfunction

  function automatic logic op_is_sub(input logic [2:0] op);
    return op[2];
  endfunction

  function automatic logic op_uses_imm(input logic [2:0] op);
    return op[2:1] == 2'b01;
  endfunction

  function automatic logic op_traps(input logic [2:0] op);
    return !op[0];
  endfunction
endpackage

// File: rtl/ts_operand_sel.sv
module ts_operand_sel
  import trap_addsub_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] b_sel_o,
  output logic [DATA_W-1:0] b_add_o,
  output logic              cin_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    end else begin : g_trunc
      assign imm_ext = imm_i[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    b_sel_o = op_uses_imm(op_i) ? imm_ext : opb_i;
    // subtract: invert here, +1 enters as carry
    b_add_o = op_is_sub(op_i) ? ~b_sel_o : b_sel_o;
    cin_o   = op_is_sub(op_i);
  end
endmodule

// File: rtl/ts_adder_ovf.sv
module ts_adder_ovf #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_sel_i,
  input  logic [DATA_W-1:0] b_add_i,
  input  logic              cin_i,
  input  logic              is_sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              ovf_o
);
  localparam int MSB = DATA_W - 1;

  logic a_s, b_s, r_s;

  always_comb begin
    sum_o = a_i + b_add_i + {{(DATA_W-1){1'b0}}, cin_i};
    a_s   = a_i[MSB];
    b_s   = b_sel_i[MSB];
    r_s   = sum_o[MSB];
    // sign rule on the un-inverted operand
    if (is_sub_i) ovf_o = (a_s != b_s) && (r_s != a_s);
    else          ovf_o = (a_s == b_s) && (r_s != a_s);
  end
endmodule

// File: rtl/ts_out_stage.sv
module ts_out_stage
  import trap_addsub_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              trap_en_i,
  input  logic              is_sub_i,
  input  logic [DATA_W-1:0] sum_i,
  input  logic              ovf_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [DATA_W-1:0] result_o,
  output logic              ovf_o,
  output logic              wr_en_o,
  output logic              exc_o,
  output logic [ADDR_W-1:0] epc_o,
  output logic [1:0]        cause_o
);
  logic trap;
  assign trap = accept_i && trap_en_i && ovf_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      ovf_o    <= 1'b0;
      wr_en_o  <= 1'b0;
      exc_o    <= 1'b0;
      epc_o    <= '0;
      cause_o  <= CAUSE_NONE;
    end else begin
      wr_en_o <= accept_i && !trap;
      exc_o   <= trap;
      if (accept_i) begin
        result_o <= sum_i;
        ovf_o    <= ovf_i;
      end
      if (trap) begin
        epc_o   <= pc_i;
        cause_o <= is_sub_i ? CAUSE_SUB : CAUSE_ADD;
      end
    end
  end
endmodule

// File: rtl/trap_addsub.sv
module trap_addsub
  import trap_addsub_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [DATA_W-1:0] result_o,
  output logic              ovf_o,
  output logic              wr_en_o,
  output logic              exc_o,
  output logic [ADDR_W-1:0] epc_o,
  output logic [1:0]        cause_o
);
  logic [DATA_W-1:0] b_sel, b_add, sum;
  logic              cin, ovf, accept;

  assign accept = valid_i && op_legal(op_i);

  ts_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
    .op_i   (op_i),
    .opb_i  (opb_i),
    .imm_i  (imm_i),
    .b_sel_o(b_sel),
    .b_add_o(b_add),
    .cin_o  (cin)
  );

  ts_adder_ovf #(.DATA_W(DATA_W)) u_add (
    .a_i     (opa_i),
    .b_sel_i (b_sel),
    .b_add_i (b_add),
    .cin_i   (cin),
    .is_sub_i(op_is_sub(op_i)),
    .sum_o   (sum),
    .ovf_o   (ovf)
  );

  ts_out_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .trap_en_i(op_traps(op_i)),
    .is_sub_i (op_is_sub(op_i)),
    .sum_i    (sum),
    .ovf_i    (ovf),
    .pc_i     (pc_i),
    .result_o (result_o),
    .ovf_o    (ovf_o),
    .wr_en_o  (wr_en_o),
    .exc_o    (exc_o),
    .epc_o    (epc_o),
    .cause_o  (cause_o)
  );
endmodule

// File: rtl/trap_addsub_chk.sv
module trap_addsub_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [DATA_W-1:0] opb_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [DATA_W-1:0] result_o,
  input logic              ovf_o,
  input logic              wr_en_o,
  input logic              exc_o,
  input logic [ADDR_W-1:0] epc_o,
  input logic [1:0]        cause_o
);
  localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  a_r2_add_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 3'b000 |=> result_o == $past(opa_i + opb_i));

  a_r7_trap_blocks_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> !wr_en_o);

  a_r8_no_trap_unsigned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i[0] |=> !exc_o);

  a_r9_epc_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> epc_o == $past(pc_i));

  a_r9_epc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_o |-> $stable(epc_o) && $stable(cause_o));

  a_r10_min_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 3'b100 && opb_i == MIN_V && !opa_i[DATA_W-1] |=> ovf_o && exc_o);

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !wr_en_o && !exc_o && $stable(result_o) && $stable(ovf_o));
endmodule

bind trap_addsub trap_addsub_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .opa_i(opa_i), .opb_i(opb_i), .imm_i(imm_i), .pc_i(pc_i),
  .result_o(result_o), .ovf_o(ovf_o), .wr_en_o(wr_en_o), .exc_o(exc_o),
  .epc_o(epc_o), .cause_o(cause_o)
);

// File: tb/tb_trap_addsub.sv
module tb_trap_addsub;
  localparam int DW = 6;
  localparam int IW = 4;
  localparam int AW = 8;
  localparam int MOD  = 1 << DW;
  localparam int HALF = 1 << (DW - 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [2:0]    op = 3'b000;
  logic [DW-1:0] opa = '0, opb = '0;
  logic [IW-1:0] imm = '0;
  logic [AW-1:0] pc = '0;
  logic [DW-1:0] result;
  logic          ovf, wr_en, exc;
  logic [AW-1:0] epc;
  logic [1:0]    cause;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int e_res = 0, e_ovf = 0, e_epc = 0, e_cause = 0;
  int pc_cnt = 0;

  always #2 clk = ~clk;

  trap_addsub #(.DATA_W(DW), .IMM_W(IW), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .opa_i(opa), .opb_i(opb), .imm_i(imm), .pc_i(pc),
    .result_o(result), .ovf_o(ovf), .wr_en_o(wr_en), .exc_o(exc),
    .epc_o(epc), .cause_o(cause)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (op=%0d a=%0d b=%0d imm=%0d)",
               req, act, exp, op, opa, opb, imm);
    end
  endtask

  function automatic int sval(input int v, input int w);
    return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
  endfunction

  // one strobe cycle; outputs checked one edge later
  task automatic run_op(input bit v, input int o, input int a, input int b, input int im);
    int sa, sb, tr, t_res, t_ovf;
    bit legal, is_sub, trap;
    string rtag, otag;
    @(negedge clk);
    valid = v; op = 3'(o); opa = DW'(a); opb = DW'(b); imm = IW'(im);
    pc = AW'(pc_cnt);
    legal  = v && (o < 6);
    is_sub = (o >= 4);
    sa = sval(a, DW);
    sb = (o == 2 || o == 3) ? sval(im, IW) : sval(b, DW);
    tr = is_sub ? sa - sb : sa + sb;
    t_res = ((tr % MOD) + MOD) % MOD;
    t_ovf = (tr >= HALF || tr < -HALF) ? 1 : 0;
    trap  = legal && t_ovf == 1 && (o % 2 == 0);
    @(posedge clk);
    #1;
    if (legal) begin
      e_res = t_res; e_ovf = t_ovf;
    end
    if (trap) begin
      e_epc = pc_cnt % (1 << AW); e_cause = is_sub ? 2 : 1;
    end
    rtag = is_sub ? "R4" : ((o == 2 || o == 3) ? "R3" : "R2");
    otag = is_sub ? "R6" : "R5";
    if (!legal) begin
      chk("R11 result held", int'(result), e_res);
      chk("R11 ovf held", int'(ovf), e_ovf);
      chk("R11 wr_en low", int'(wr_en), 0);
      chk("R11 exc low", int'(exc), 0);
    end else begin
      chk(rtag, int'(result), e_res);
      chk(otag, int'(ovf), e_ovf);
      if (o % 2 == 0) begin
        chk("R7 exc", int'(exc), trap ? 1 : 0);
        chk("R7 wr_en", int'(wr_en), trap ? 0 : 1);
      end else begin
        chk("R8 exc", int'(exc), 0);
        chk("R8 wr_en", int'(wr_en), 1);
      end
    end
    chk("R9 epc", int'(epc), e_epc);
    chk("R9 cause", int'(cause), e_cause);
    pc_cnt++;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 result", int'(result), 0);
    chk("R1 ovf", int'(ovf), 0);
    chk("R1 wr_en", int'(wr_en), 0);
    chk("R1 exc", int'(exc), 0);
    chk("R1 epc", int'(epc), 0);
    chk("R1 cause", int'(cause), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int o = 0; o < 6; o++) begin
      for (int a = 0; a < MOD; a++) begin
        run_op(1'b0, o, a, a, 0);            // R11 idle between runs
        if (o == 2 || o == 3) begin
          for (int im = 0; im < (1 << IW); im++)
            run_op(1'b1, o, a, (~a) & (MOD - 1), im);  // opb ignored (R3)
        end else begin
          for (int b = 0; b < MOD; b++)
            run_op(1'b1, o, a, b, 0);
        end
      end
    end

    // R10: most negative subtrahend, non-negative minuend
    run_op(1'b1, 4, 0, HALF, 0);
    chk("R10 ovf", int'(ovf), 1);
    chk("R10 exc", int'(exc), 1);
    run_op(1'b1, 5, HALF - 1, HALF, 0);
    chk("R10 ovf unsigned", int'(ovf), 1);
    chk("R10 no exc unsigned", int'(exc), 0);

    // R11: reserved codes
    run_op(1'b1, 6, 31, 31, 0);
    run_op(1'b1, 7, HALF, HALF, 0);
    run_op(1'b0, 0, 1, 2, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule